// File: doc/BRIEF.md
# Daisy-Chained Six-Source Interrupt Controller

This block gathers interrupt requests from two serial channels. Each channel has three kinds of request: receive, transmit and external/status. The block keeps an enable bit, a pending bit and an under-service bit for each of the six sources. It ranks them by a fixed priority and joins that ranking to an external daisy chain through a chain-in input (`iei`) and a chain-out output (`ieo`). While a source is ready to be serviced, an active-low request line is driven low. The CPU answers with an acknowledge cycle, marked by `intack_n` and a falling data strobe. In that cycle the block drives an 8-bit vector and marks the winning source as under service.

Request conditions do not become pending right away. They pass through a two-stage pipeline that advances on rising edges of the address strobe. Software uses one write port to set up the block: the vector register, the master enable, the status-in-vector option and the per-source enables. The same port issues commands that clear pending bits and release the highest-priority under-service bit. The pending bits can be read on a port at all times. A plain vector readout and a status-carrying vector readout are both available as outputs.

Top module: `irq_chain_ctrl`

## Requirements

- R1: Sources have bit indices 0 to 5: 0 = A receive, 1 = A transmit, 2 = A ext/status, 3 = B receive, 4 = B transmit, 5 = B ext/status. Index 0 has the highest priority. The 3-bit status code of the top request is: A receive 110, A transmit 100, A ext 101, B receive 010, B transmit 000, B ext 001. When no request exists the code is 011.
- R2: A condition on a source whose enable bit is clear never sets that source's pending bit. Clearing an enable bit clears that source's pending bit. Enables are written with `wr_sel`=2, bits 5:0 in source-index order.
- R3: While the master enable (`wr_sel`=1, bit 0) is clear, `int_n` stays high and acknowledge cycles get no response. Pending bits may still be set.
- R4: `int_n` is low exactly when `iei` is high, the master enable is set, and some pending source is not blocked by under-service.
- R5: A pending bit is set on the second rising edge of `as_n` after its condition is captured, and not on the first.
- R6: A set under-service bit blocks its own source and every lower-priority source. While any under-service bit is set, `ieo` is low.
- R7: When no under-service bit is set, `ieo` follows `iei`. The exception is an acknowledge cycle (`intack_n` low) while a request exists; then `ieo` is low.
- R8: When `ds_n` falls while `intack_n` is low, `iei` is high and a request exists, the block does three things: it sets `vec_oe`, drives the vector on `vec_out`, and sets the under-service bit of the top request. `vec_oe` drops once `ds_n` is high again. If `iei` is low, or no request exists, there is no response.
- R9: `vec_a` always shows the written vector (`wr_sel`=0) unchanged. `vec_b` always shows it with bits 3:1 replaced by the status code. The acknowledge vector carries the status code only when the status option (`wr_sel`=1, bit 1) is set.
- R10: A command write (`wr_sel`=3) with bit 6 set clears only the highest-priority under-service bit. In the same write, bits 5:0 clear the matching pending bits.
- R11: A transmit condition occurs only when the transmit-empty input rises after a character write (`tx_wr`) has armed that channel. A rise of the empty input with no write before it causes nothing.
- R12: A receive condition that comes with `rx_special` high marks the channel special. The receive status code then becomes 111 for A and 011 for B, until that receive pending bit is cleared.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| intack_n | input | 1 | Interrupt acknowledge, active low |
| iei | input | 1 | Priority chain in, high = enabled |
| ieo | output | 1 | Priority chain out |
| int_n | output | 1 | Interrupt request, active low |
| rx_evt | input | 2 | Receive condition pulse per channel ([0]=A) |
| rx_special | input | 2 | Receive condition is special, per channel |
| ext_evt | input | 2 | External/status condition pulse per channel |
| tx_wr | input | 2 | Character written to transmit buffer, per channel |
| tx_empty | input | 2 | Transmit buffer empty level, per channel |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 vector, 1 control, 2 enables, 3 command |
| wr_data | input | 8 | Register write data |
| pend | output | 6 | Pending bits in source-index order |
| vec_a | output | 8 | Vector read without status |
| vec_b | output | 8 | Vector read with status |
| vec_out | output | 8 | Vector driven in the acknowledge cycle |
| vec_oe | output | 1 | Vector output valid |

## Verification

Several source mixes are made pending together. Each one checks that the status code follows the ranking: paired ext/status requests on both channels, a special versus an ordinary receive, and nothing pending. Acknowledges are tried with `iei` high and low, with the master enable off, and with the status option off. These runs separate a chain or gating fault from a vector-formatting fault. A nested service sequence stacks a B-channel under-service bit beneath an A receive one. It then releases them one at a time and watches `ieo` and `int_n`. This shows that only the top bit is cleared and that lower sources stay blocked. Address-strobe pulses are counted one at a time to place the edge on which a pending bit appears. Transmit-empty rises are sent with and without a prior write.

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_n,
  input  logic       ds_n,
  input  logic       intack_n,
  input  logic       iei,
  output logic       ieo,
  output logic       int_n,
  input  logic [1:0] rx_evt,
  input  logic [1:0] rx_special,
  input  logic [1:0] ext_evt,
  input  logic [1:0] tx_wr,
  input  logic [1:0] tx_empty,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [5:0] pend,
  output logic [7:0] vec_a,
  output logic [7:0] vec_b,
  output logic [7:0] vec_out,
  output logic       vec_oe
);

  logic [7:0] vec_reg;
  logic       mie, vis;
  logic [5:0] ien, c0, c1, ius;
  logic [1:0] tx_arm, tx_empty_q, spec;
  logic       as_q, ds_q;
  logic [2:0] code;

  wire [1:0] tx_fire = tx_arm & tx_empty & ~tx_empty_q;
  wire [5:0] ev      = {ext_evt[1], tx_fire[1], rx_evt[1], ext_evt[0], tx_fire[0], rx_evt[0]};
  wire       as_rise = as_n & ~as_q;
  wire       ds_fall = ~ds_n & ds_q;

  wire       wr_vec  = wr_en && wr_sel == 2'd0;
  wire       wr_ctl  = wr_en && wr_sel == 2'd1;
  wire       wr_ien  = wr_en && wr_sel == 2'd2;
  wire       wr_cmd  = wr_en && wr_sel == 2'd3;
  wire       cmd_rst = wr_cmd & wr_data[6];
  wire [5:0] clr     = wr_cmd ? wr_data[5:0] : 6'd0;
  wire [5:0] ien_nx  = wr_ien ? wr_data[5:0] : ien;

  wire [5:0] ius_top = ius & (~ius + 6'd1);
  wire [5:0] blocked = (ius == 6'd0) ? 6'd0 : ~(ius_top - 6'd1);
  wire [5:0] req     = pend & ~blocked & {6{mie}};
  wire [5:0] top     = req & (~req + 6'd1);
  wire       any_req = |req;
  wire       ack     = ds_fall & ~intack_n & iei & any_req;

  always_comb begin
    case (top)
      6'b000001: code = spec[0] ? 3'b111 : 3'b110;
      6'b000010: code = 3'b100;
      6'b000100: code = 3'b101;
      6'b001000: code = spec[1] ? 3'b011 : 3'b010;
      6'b010000: code = 3'b000;
      6'b100000: code = 3'b001;
      default:   code = 3'b011;
    endcase
  end

  assign vec_a = vec_reg;
  assign vec_b = {vec_reg[7:4], code, vec_reg[0]};
  assign int_n = ~(iei & any_req);
  assign ieo   = iei & ~(|ius) & ~(~intack_n & any_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_reg <= 8'd0;  mie <= 1'b0;  vis <= 1'b0;  ien <= 6'd0;
      c0 <= 6'd0;  c1 <= 6'd0;  pend <= 6'd0;  ius <= 6'd0;
      tx_arm <= 2'd0;  tx_empty_q <= 2'd0;  spec <= 2'd0;
      as_q <= 1'b1;  ds_q <= 1'b1;  vec_out <= 8'd0;  vec_oe <= 1'b0;
    end else begin
      as_q       <= as_n;
      ds_q       <= ds_n;
      tx_empty_q <= tx_empty;
      tx_arm     <= (tx_arm & ~tx_fire) | tx_wr;
      if (wr_vec) vec_reg <= wr_data;
      if (wr_ctl) begin mie <= wr_data[0]; vis <= wr_data[1]; end
      ien <= ien_nx;
      c0  <= ((as_rise ? 6'd0 : c0) | ev) & ien_nx;
      if (as_rise) c1 <= c0 & ien_nx;
      else         c1 <= c1 & ien_nx;
      pend <= (pend | (as_rise ? c1 : 6'd0)) & ~clr & ien_nx;
      for (int c = 0; c < 2; c++) begin
        if (clr[3*c] || !ien_nx[3*c]) spec[c] <= 1'b0;
        else if (rx_evt[c] && rx_special[c]) spec[c] <= 1'b1;
      end
      ius <= (cmd_rst ? (ius & (ius - 6'd1)) : ius) | (ack ? top : 6'd0);
      if (ack) begin
        vec_oe  <= 1'b1;
        vec_out <= vis ? vec_b : vec_reg;
      end else if (ds_n) vec_oe <= 1'b0;
    end
  end

  a_r2_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~ien) == 6'd0);
  a_r3_mie_holds_int: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |-> int_n);
  a_r4_int_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> iei);
  a_r6_ius_pulls_ieo: assert property (@(posedge clk) disable iff (!rst_n)
    (ius != 6'd0) |-> !ieo);
  a_r8_ack_adds_one_ius: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cmd_rst) |=> ($countones(ius) == $countones($past(ius)) + 1) && vec_oe);
  a_r10_release_one_ius: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rst && !ack && ius != 6'd0) |=> $countones(ius) + 1 == $countones($past(ius)));

endmodule

// File: tb/sim_irq_chain_ctrl.sv
`timescale 1ns/1ps
module sim_irq_chain_ctrl;
  logic clk = 0, rst_n = 0;
  logic as_n = 1, ds_n = 1, intack_n = 1, iei = 1;
  logic [1:0] rx_evt = 0, rx_special = 0, ext_evt = 0, tx_wr = 0, tx_empty = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic ieo, int_n, vec_oe;
  logic [5:0] pend;
  logic [7:0] vec_a, vec_b, vec_out;
  int checks = 0, errors = 0;
  logic [7:0] av;
  logic aoe;

  always #5 clk = ~clk;

  irq_chain_ctrl u0 (.clk, .rst_n, .as_n, .ds_n, .intack_n, .iei, .ieo, .int_n,
    .rx_evt, .rx_special, .ext_evt, .tx_wr, .tx_empty, .wr_en, .wr_sel, .wr_data,
    .pend, .vec_a, .vec_b, .vec_out, .vec_oe);

  task automatic tick; @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick; wr_en = 0;
  endtask

  task automatic as_pulse; as_n = 0; tick; as_n = 1; tick; endtask

  task automatic ev_rx(int c, logic sp);
    rx_evt[c] = 1; rx_special[c] = sp; tick; rx_evt = 0; rx_special = 0;
  endtask

  task automatic ev_ext(logic [1:0] m); ext_evt = m; tick; ext_evt = 0; endtask

  task automatic do_ack(output logic [7:0] v, output logic oe);
    intack_n = 0; tick; ds_n = 0; tick;
    v = vec_out; oe = vec_oe;
    ds_n = 1; intack_n = 1; tick;
  endtask

  task automatic t_reset;
    chk("R4 reset int_n", int_n, 1);
    chk("R2 reset pend", pend, 0);
    chk("R7 reset ieo", ieo, 1);
    chk("R8 reset vec_oe", vec_oe, 0);
    chk("R9 reset vec_a", vec_a, 0);
  endtask

  task automatic t_enable_and_delay;
    wr(2, 8'h3e);
    ev_rx(0, 0); as_pulse; as_pulse;
    chk("R2 disabled source stays clear", pend, 0);
    wr(2, 8'h3f);
    ev_rx(0, 0); as_pulse;
    chk("R5 not pending after first AS rise", pend, 0);
    as_pulse;
    chk("R5 pending after second AS rise", pend, 6'h01);
    chk("R4 int_n low with request", int_n, 0);
    wr(2, 8'h3e);
    chk("R2 disable clears pending", pend, 0);
    wr(2, 8'h3f);
  endtask

  task automatic t_codes;
    ev_ext(2'b11); as_pulse; as_pulse;
    chk("R1 both ext pending", pend, 6'h24);
    chk("R9 vec_a raw", vec_a, 8'hA0);
    chk("R1 R9 vec_b A ext code", vec_b, 8'hAA);
    chk("R7 ieo follows iei outside ack", ieo, 1);
    do_ack(av, aoe);
    chk("R8 vec_oe in ack", aoe, 1);
    chk("R8 ack vector", av, 8'hAA);
    chk("R8 vec_oe drops after ds high", vec_oe, 0);
    chk("R6 self and lower blocked", int_n, 1);
    chk("R6 ieo low under service", ieo, 0);
    wr(3, 8'h64);
    chk("R10 cleared", ieo, 1);
    chk("R10 pending cleared", pend, 0);
    ev_rx(0, 1); as_pulse; as_pulse;
    chk("R12 A special code", vec_b, 8'hAE);
    wr(3, 8'h01);
    chk("R1 none code", vec_b, 8'hA6);
    ev_rx(1, 0); as_pulse; as_pulse;
    chk("R1 B receive code", vec_b, 8'hA4);
    ev_rx(0, 0); as_pulse; as_pulse;
    chk("R12 special gone after clear", vec_b, 8'hAC);
    wr(3, 8'h09);
    wr(1, 8'h01);
    ev_ext(2'b10); as_pulse; as_pulse;
    do_ack(av, aoe);
    chk("R9 ack vector without status", av, 8'hA0);
    wr(3, 8'h60);
    wr(1, 8'h03);
  endtask

  task automatic t_master;
    wr(1, 8'h02);
    ev_rx(0, 0); as_pulse; as_pulse;
    chk("R3 pending still sets", pend, 6'h01);
    chk("R3 int_n held high", int_n, 1);
    do_ack(av, aoe);
    chk("R3 no ack response", aoe, 0);
    wr(1, 8'h03);
    chk("R3 int_n low once enabled", int_n, 0);
  endtask

  task automatic t_chain;
    iei = 0; tick;
    chk("R4 iei low holds int_n", int_n, 1);
    chk("R7 ieo follows low iei", ieo, 0);
    do_ack(av, aoe);
    chk("R8 no response with iei low", aoe, 0);
    iei = 1; tick;
    intack_n = 0; tick;
    chk("R7 ieo low in ack with request", ieo, 0);
    intack_n = 1; tick;
    chk("R7 ieo back high", ieo, 1);
    wr(3, 8'h01);
    intack_n = 0; tick;
    chk("R7 ieo high in ack, nothing pending", ieo, 1);
    intack_n = 1; tick;
  endtask

  task automatic t_nest;
    ev_ext(2'b10); as_pulse; as_pulse;
    do_ack(av, aoe);
    chk("R8 B ext vector", av, 8'hA2);
    ev_rx(0, 0); as_pulse; as_pulse;
    chk("R6 higher source still requests", int_n, 0);
    do_ack(av, aoe);
    chk("R8 nested A receive vector", av, 8'hAC);
    ev_rx(1, 0); as_pulse; as_pulse;
    chk("R6 B receive blocked", int_n, 1);
    wr(3, 8'h29);
    wr(3, 8'h40);
    chk("R10 only top released", ieo, 0);
    wr(3, 8'h40);
    chk("R10 second release", ieo, 1);
  endtask

  task automatic t_tx;
    tx_empty = 2'b01; tick; tx_empty = 0; tick; tx_empty = 2'b01; tick;
    as_pulse; as_pulse;
    chk("R11 no write no interrupt", pend, 0);
    tx_empty = 0; tx_wr = 2'b01; tick; tx_wr = 0; tick;
    tx_empty = 2'b01; tick;
    as_pulse; as_pulse;
    chk("R11 empty after write", pend, 6'h02);
    chk("R1 A transmit code", vec_b, 8'hA8);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    t_reset;
    wr(0, 8'hA0); wr(1, 8'h03); wr(2, 8'h3f);
    t_enable_and_delay;
    t_codes;
    t_master;
    t_chain;
    t_nest;
    t_tx;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule